// File: doc/BRIEF.md
# Configurable Video Pixel Input Capture

This block is the front end of a video link transmitter. It samples a parallel pixel bus on a pixel clock and turns each capture into complete 24-bit pixels. Configuration inputs choose the bus format: a 12-bit bus carrying each pixel as two halves, one pixel per capture at 18 or 24 bits, or two pixels per capture at 36 or 48 bits. They also choose whether captures happen on the rising edge, the falling edge or both.

Falling-edge captures go into a register clocked on the falling edge. The next rising edge merges them with the rising-edge capture. On every rising edge the block presents two pixel lanes, each with its own valid flag, together with the data-enable level sampled at that edge. An 18-bit pixel is widened to 24 bits before it reaches the output. Combinations of format and edge that are not allowed raise an error flag, and no pixels are produced while the flag is set.

Top module: `pixcap_top`

## Requirements
- R1: Half format (cfg_fmt=0) with cfg_half_order=0 works as follows. A capture at a rising edge with data-enable high holds the low 12 bits of a pixel. The falling edge that follows supplies the high 12 bits. After the next rising edge, pix0 = {high, low} with pix0_vld high, provided the falling capture also had data-enable high.
- R2: Half format with cfg_half_order=1 takes the low 12 bits at a falling edge and the high 12 bits at the following rising edge. Just after that rising edge, pix0 = {high, low} is valid if both captures had data-enable high. In half format pix1_vld stays low.
- R3: A waiting low half is dropped when data-enable is low at the falling edge, or when the configuration {cfg_fmt, cfg_wide, cfg_edge, cfg_half_order} differs from its value at the previous rising edge. A rising capture with data-enable high always starts a new pair.
- R4: Full format (cfg_fmt=1) with cfg_edge=0 (rising) or cfg_edge=1 (falling) gives one pixel on lane 0 from the selected edge. pix1_vld stays low.
- R5: Full format with cfg_edge=2 (both) puts the falling capture on lane 0 and the rising capture that follows it on lane 1. Each lane has its own valid flag, taken from its own data-enable.
- R6: With cfg_wide=0, a pixel occupies bits [17:0] of its slot as three 6-bit colours at [5:0], [11:6] and [17:12]. Each colour becomes the 8-bit field {c, c[5:4]} at [7:0], [15:8] and [23:16]. Bus bits above the 18-bit slot are ignored. With cfg_wide=1 the 24 bits pass unchanged.
- R7: Double format (cfg_fmt=2) samples on the edge chosen by cfg_edge=0 or 1. Pixel n comes from bits [23:0] (wide) or [17:0] (narrow) and goes to lane 0. Pixel n+1 comes from bits [47:24] or [35:18] and goes to lane 1. Both lanes are valid when that capture's data-enable is high.
- R8: config_error is set, and both valid flags are held low, for any of these settings: cfg_fmt=3; cfg_edge=3; half format without cfg_edge=2; double format with cfg_edge=2.
- R9: A capture taken while bus_de is low produces no valid pixel. de_out shows bus_de as sampled at the latest rising edge.
- R10: While rst_n is low, every output is zero.
- R11: Every output is registered on the rising edge that closes the capture window. That window covers the falling edge just before the rising edge and the rising edge itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock; both edges capture |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_fmt | input | 2 | Bus format: 0 half, 1 full, 2 double, 3 reserved |
| cfg_wide | input | 1 | 1 = 24-bit pixels, 0 = 18-bit pixels |
| cfg_edge | input | 2 | Capture edge: 0 rising, 1 falling, 2 both, 3 reserved |
| cfg_half_order | input | 1 | Half format order: 0 low on rising, 1 low on falling |
| bus_data | input | 48 | Parallel pixel bus |
| bus_de | input | 1 | Data-enable, sampled with bus_data |
| pix0 | output | 24 | Lane 0 pixel (earlier pixel) |
| pix0_vld | output | 1 | Lane 0 valid |
| pix1 | output | 24 | Lane 1 pixel (later pixel) |
| pix1_vld | output | 1 | Lane 1 valid |
| de_out | output | 1 | Data-enable sampled at the last rising edge |
| config_error | output | 1 | Illegal format and edge setting |

## Verification
The bench drives different data at the two edges of every cycle. A design that swapped the lanes in both-edge mode, or read the wrong edge in single-edge modes, would therefore show the wrong value on the wrong lane. In half format it drops data-enable and changes the configuration between the two halves of a pixel. A design that kept a stale low half would then emit a pixel made from halves of two different pixels. Narrow pixels are sent with junk in the unused upper bits, so zero-filling or leaking those bits shows up as a value mismatch. Every illegal combination is tried, so any pixel that leaks out under an error setting is caught.

// File: rtl/pixcap_pkg.sv
package pixcap_pkg;

    typedef enum logic [1:0] {
        FMT_HALF   = 2'd0,
        FMT_FULL   = 2'd1,
        FMT_DOUBLE = 2'd2,
        FMT_RSVD   = 2'd3
    } fmt_e;

    typedef enum logic [1:0] {
        EDGE_RISE = 2'd0,
        EDGE_FALL = 2'd1,
        EDGE_BOTH = 2'd2,
        EDGE_RSVD = 2'd3
    } edge_e;

    localparam int NUM_LANES = 2;
    localparam int NUM_COLOURS = 3;

endpackage

// File: rtl/pixcap_fall_reg.sv
module pixcap_fall_reg #(
    parameter int W = 49
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] fall_d, fall_q;

    always_comb begin
        fall_d = d;
    end

    // capture on the falling edge; the rising-edge logic reads it half a cycle later
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) fall_q <= '0;
        else        fall_q <= fall_d;
    end

    assign q = fall_q;
endmodule

// File: rtl/pixcap_lane_route.sv
module pixcap_lane_route import pixcap_pkg::*; #(
    parameter int PIX_W = 24
) (
    input  logic [1:0]         fmt,
    input  logic [1:0]         edge_sel,
    input  logic               wide,
    input  logic [2*PIX_W-1:0] f_dat,
    input  logic               f_de,
    input  logic [2*PIX_W-1:0] r_dat,
    input  logic               r_de,
    output logic [PIX_W-1:0]   raw0,
    output logic [PIX_W-1:0]   raw1,
    output logic               v0,
    output logic               v1
);
    localparam int BUS_W  = 2 * PIX_W;
    localparam int NPIX_W = (PIX_W / NUM_COLOURS - 2) * NUM_COLOURS;

    logic [BUS_W-1:0] s_dat;
    logic             s_de;

    always_comb begin
        // double format reads a single edge
        s_dat = (edge_sel == EDGE_FALL) ? f_dat : r_dat;
        s_de  = (edge_sel == EDGE_FALL) ? f_de  : r_de;
        raw0 = '0;
        raw1 = '0;
        v0   = 1'b0;
        v1   = 1'b0;
        unique case (fmt)
            FMT_DOUBLE: begin
                raw0 = wide ? s_dat[PIX_W-1:0]     : PIX_W'(s_dat[NPIX_W-1:0]);
                raw1 = wide ? s_dat[BUS_W-1:PIX_W] : PIX_W'(s_dat[2*NPIX_W-1:NPIX_W]);
                v0   = s_de;
                v1   = s_de;
            end
            FMT_FULL: begin
                unique case (edge_sel)
                    EDGE_RISE: begin
                        raw0 = r_dat[PIX_W-1:0];
                        v0   = r_de;
                    end
                    EDGE_FALL: begin
                        raw0 = f_dat[PIX_W-1:0];
                        v0   = f_de;
                    end
                    EDGE_BOTH: begin
                        raw0 = f_dat[PIX_W-1:0];
                        v0   = f_de;
                        raw1 = r_dat[PIX_W-1:0];
                        v1   = r_de;
                    end
                    default: ;
                endcase
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/pixcap_lane_expand.sv
module pixcap_lane_expand import pixcap_pkg::*; #(
    parameter int PIX_W = 24
) (
    input  logic [PIX_W-1:0] raw,
    input  logic             wide,
    output logic [PIX_W-1:0] pix
);
    localparam int CH_W  = PIX_W / NUM_COLOURS;
    localparam int NCH_W = CH_W - 2;

    logic [PIX_W-1:0] narrow_x;

    // each narrow colour moves to the top of its field; its two MSBs refill the bottom
    for (genvar ch = 0; ch < NUM_COLOURS; ch++) begin : g_ch
        assign narrow_x[ch*CH_W +: CH_W] =
            {raw[ch*NCH_W +: NCH_W], raw[ch*NCH_W + NCH_W - 1 -: 2]};
    end

    assign pix = wide ? raw : narrow_x;
endmodule

// File: rtl/pixcap_top.sv
module pixcap_top import pixcap_pkg::*; #(
    parameter int PIX_W = 24
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [1:0]         cfg_fmt,
    input  logic               cfg_wide,
    input  logic [1:0]         cfg_edge,
    input  logic               cfg_half_order,
    input  logic [2*PIX_W-1:0] bus_data,
    input  logic               bus_de,
    output logic [PIX_W-1:0]   pix0,
    output logic               pix0_vld,
    output logic [PIX_W-1:0]   pix1,
    output logic               pix1_vld,
    output logic               de_out,
    output logic               config_error
);
    localparam int BUS_W  = 2 * PIX_W;
    localparam int HALF_W = PIX_W / 2;
    localparam int CFG_W  = 6;

    typedef struct packed {
        logic [PIX_W-1:0]  pix0;
        logic [PIX_W-1:0]  pix1;
        logic              vld0;
        logic              vld1;
        logic              de;
        logic              err;
        logic              pend;
        logic [HALF_W-1:0] low;
        logic [CFG_W-1:0]  cfg;
    } state_t;

    state_t s_d, s_q;

    // falling-edge capture path
    logic [BUS_W:0]   fall_q;
    logic [BUS_W-1:0] f_dat;
    logic             f_de;

    pixcap_fall_reg #(.W(BUS_W + 1)) fall_i (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({bus_de, bus_data}),
        .q     (fall_q)
    );

    assign f_dat = fall_q[BUS_W-1:0];
    assign f_de  = fall_q[BUS_W];

    // lane routing for full and double formats
    logic [PIX_W-1:0] raw_l [NUM_LANES];
    logic [PIX_W-1:0] exp_l [NUM_LANES];
    logic             v0, v1;

    pixcap_lane_route #(.PIX_W(PIX_W)) route_i (
        .fmt      (cfg_fmt),
        .edge_sel (cfg_edge),
        .wide     (cfg_wide),
        .f_dat    (f_dat),
        .f_de     (f_de),
        .r_dat    (bus_data),
        .r_de     (bus_de),
        .raw0     (raw_l[0]),
        .raw1     (raw_l[1]),
        .v0       (v0),
        .v1       (v1)
    );

    for (genvar ln = 0; ln < NUM_LANES; ln++) begin : g_lane
        pixcap_lane_expand #(.PIX_W(PIX_W)) exp_i (
            .raw  (raw_l[ln]),
            .wide (cfg_wide),
            .pix  (exp_l[ln])
        );
    end

    logic [CFG_W-1:0] cfg_now;
    logic             illegal;
    logic             cfg_chg;

    always_comb begin
        cfg_now = {cfg_fmt, cfg_wide, cfg_edge, cfg_half_order};
        illegal = (cfg_fmt == FMT_RSVD) || (cfg_edge == EDGE_RSVD)
               || ((cfg_fmt == FMT_HALF)   && (cfg_edge != EDGE_BOTH))
               || ((cfg_fmt == FMT_DOUBLE) && (cfg_edge == EDGE_BOTH));
        cfg_chg = (cfg_now != s_q.cfg);

        s_d      = s_q;
        s_d.cfg  = cfg_now;
        s_d.err  = illegal;
        s_d.de   = bus_de;
        s_d.vld0 = 1'b0;
        s_d.vld1 = 1'b0;
        s_d.pend = 1'b0;

        if (!illegal) begin
            if (cfg_fmt == FMT_HALF) begin
                if (!cfg_half_order) begin
                    // low half waited since last rising edge; high half came on the falling edge
                    if (s_q.pend && !cfg_chg && f_de) begin
                        s_d.pix0 = {f_dat[HALF_W-1:0], s_q.low};
                        s_d.vld0 = 1'b1;
                    end
                    s_d.pend = bus_de;
                    s_d.low  = bus_data[HALF_W-1:0];
                end else if (f_de && bus_de) begin
                    // low half on the falling edge, high half now
                    s_d.pix0 = {bus_data[HALF_W-1:0], f_dat[HALF_W-1:0]};
                    s_d.vld0 = 1'b1;
                end
            end else begin
                s_d.vld0 = v0;
                s_d.vld1 = v1;
                if (v0) s_d.pix0 = exp_l[0];
                if (v1) s_d.pix1 = exp_l[1];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign pix0         = s_q.pix0;
    assign pix0_vld     = s_q.vld0;
    assign pix1         = s_q.pix1;
    assign pix1_vld     = s_q.vld1;
    assign de_out       = s_q.de;
    assign config_error = s_q.err;
endmodule

// File: rtl/pixcap_checker.sv
module pixcap_checker (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] cfg_fmt,
    input logic [1:0] cfg_edge,
    input logic       cfg_half_order,
    input logic       bus_de,
    input logic       pix0_vld,
    input logic       pix1_vld,
    input logic       config_error
);
    logic armed;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    // R8: error setting forbids any valid lane
    p_err_blocks_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
        config_error |-> (!pix0_vld && !pix1_vld));

    // R8: reserved format code is flagged
    p_rsvd_fmt_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $past(cfg_fmt) == 2'd3) |-> config_error);

    // R2: half format never fills lane 1
    p_half_lane1_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $past(cfg_fmt) == 2'd0) |-> !pix1_vld);

    // R2: order 1 needs data-enable at the rising edge
    p_half_ord1_de_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $past(cfg_fmt) == 2'd0 && $past(cfg_half_order) && !$past(bus_de))
        |-> !pix0_vld);

    // R4: single-edge full format uses lane 0 only
    p_full_single_lane_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $past(cfg_fmt) == 2'd1 && $past(cfg_edge) != 2'd2) |-> !pix1_vld);

    // R7: double format lanes are valid together
    p_double_pair_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $past(cfg_fmt) == 2'd2 && !config_error) |-> (pix0_vld == pix1_vld));

    // R9: rising capture with data-enable low yields nothing
    p_de_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $past(cfg_fmt) == 2'd1 && $past(cfg_edge) == 2'd0 && !$past(bus_de))
        |-> !pix0_vld);
endmodule

bind pixcap_top pixcap_checker chk_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .cfg_fmt        (cfg_fmt),
    .cfg_edge       (cfg_edge),
    .cfg_half_order (cfg_half_order),
    .bus_de         (bus_de),
    .pix0_vld       (pix0_vld),
    .pix1_vld       (pix1_vld),
    .config_error   (config_error)
);

// File: tb/pixcap_top_tb_top.sv
module pixcap_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [1:0]  cfg_fmt;
    logic        cfg_wide;
    logic [1:0]  cfg_edge;
    logic        cfg_half_order;
    logic [47:0] bus_data;
    logic        bus_de;
    logic [23:0] pix0, pix1;
    logic        pix0_vld, pix1_vld, de_out, config_error;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // reference model state
    bit          m_pend = 1'b0;
    logic [11:0] m_low  = '0;
    logic [5:0]  m_prev = '0;

    always #10 clk = ~clk;

    pixcap_top dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .cfg_fmt        (cfg_fmt),
        .cfg_wide       (cfg_wide),
        .cfg_edge       (cfg_edge),
        .cfg_half_order (cfg_half_order),
        .bus_data       (bus_data),
        .bus_de         (bus_de),
        .pix0           (pix0),
        .pix0_vld       (pix0_vld),
        .pix1           (pix1),
        .pix1_vld       (pix1_vld),
        .de_out         (de_out),
        .config_error   (config_error)
    );

    function automatic logic [47:0] rnd48();
        return {$urandom(), $urandom()};
    endfunction

    // R6 widening of an 18-bit pixel
    function automatic logic [23:0] widen(logic [23:0] raw, bit wide);
        if (wide) return raw;
        return {raw[17:12], raw[17:16], raw[11:6], raw[11:10], raw[5:0], raw[5:4]};
    endfunction

    task automatic chk(string tag, string what, logic [23:0] act, logic [23:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // one pixel-clock cycle: falling-edge data, then rising-edge data, then compare
    task automatic cyc(string tag, logic [1:0] fmt, bit wide, logic [1:0] edg, bit ord,
                       logic [47:0] fd, bit fde, logic [47:0] rd, bit rde);
        logic [5:0]  cfg;
        bit          ill, chg, e0, e1;
        logic [23:0] p0, p1;
        logic [47:0] s;
        bit          sde;
        #2;
        cfg_fmt = fmt; cfg_wide = wide; cfg_edge = edg; cfg_half_order = ord;
        bus_data = fd; bus_de = fde;
        @(negedge clk); #5;
        bus_data = rd; bus_de = rde;
        @(posedge clk); #3;

        cfg = {fmt, wide, edg, ord};
        ill = (fmt == 2'd3) || (edg == 2'd3) || (fmt == 2'd0 && edg != 2'd2)
           || (fmt == 2'd2 && edg == 2'd2);
        chg = (cfg != m_prev);
        e0 = 0; e1 = 0; p0 = '0; p1 = '0;
        if (!ill) begin
            if (fmt == 2'd0) begin
                if (!ord) begin
                    if (m_pend && !chg && fde) begin p0 = {fd[11:0], m_low}; e0 = 1; end
                end else if (fde && rde) begin
                    p0 = {rd[11:0], fd[11:0]}; e0 = 1;
                end
            end else if (fmt == 2'd1) begin
                if (edg == 2'd0)      begin p0 = widen(rd[23:0], wide); e0 = rde; end
                else if (edg == 2'd1) begin p0 = widen(fd[23:0], wide); e0 = fde; end
                else begin
                    p0 = widen(fd[23:0], wide); e0 = fde;
                    p1 = widen(rd[23:0], wide); e1 = rde;
                end
            end else begin
                s = (edg == 2'd1) ? fd : rd;
                sde = (edg == 2'd1) ? fde : rde;
                if (wide) begin p0 = s[23:0]; p1 = s[47:24]; end
                else begin p0 = widen({6'd0, s[17:0]}, 0); p1 = widen({6'd0, s[35:18]}, 0); end
                e0 = sde; e1 = sde;
            end
        end
        m_pend = !ill && fmt == 2'd0 && !ord && rde;
        m_low  = rd[11:0];
        m_prev = cfg;

        chk(tag, "config_error", 24'(config_error), 24'(ill));
        chk(tag, "de_out", 24'(de_out), 24'(rde));
        chk(tag, "pix0_vld", 24'(pix0_vld), 24'(e0));
        chk(tag, "pix1_vld", 24'(pix1_vld), 24'(e1));
        if (e0) chk(tag, "pix0", pix0, p0);
        if (e1) chk(tag, "pix1", pix1, p1);
    endtask

    initial begin
        rst_n = 1'b0;
        cfg_fmt = 2'd1; cfg_wide = 1'b1; cfg_edge = 2'd0; cfg_half_order = 1'b0;
        bus_data = 48'hFFFF_FFFF_FFFF; bus_de = 1'b1;
        repeat (3) @(posedge clk);
        #3;
        // R10: reset state
        chk("R10", "pix0", pix0, '0);
        chk("R10", "pix1", pix1, '0);
        chk("R10", "valid/de/err", {20'd0, pix0_vld, pix1_vld, de_out, config_error}, '0);
        rst_n = 1'b1;

        // R4 and R9: full format, rising then falling, data-enable toggling
        for (int i = 0; i < 6; i++) cyc("R4_R9", 2'd1, 1, 2'd0, 0, rnd48(), 1, rnd48(), (i % 3) != 1);
        for (int i = 0; i < 5; i++) cyc("R4_R11", 2'd1, 1, 2'd1, 0, rnd48(), (i % 2) == 0, rnd48(), 1);
        // R5: both edges, separate data-enables
        for (int i = 0; i < 5; i++) cyc("R5", 2'd1, 1, 2'd2, 0, rnd48(), i != 2, rnd48(), i != 3);
        // R6: narrow pixels with junk in upper bits
        for (int i = 0; i < 5; i++) cyc("R6", 2'd1, 0, 2'd2, 0, rnd48(), 1, rnd48(), 1);
        cyc("R6", 2'd1, 0, 2'd0, 0, '0, 0, 48'h0000_00FC_0FC1, 1);
        // R7: double format on each edge, wide and narrow
        for (int i = 0; i < 4; i++) cyc("R7", 2'd2, 1, 2'd0, 0, rnd48(), 1, rnd48(), i != 1);
        for (int i = 0; i < 4; i++) cyc("R7", 2'd2, 0, 2'd1, 0, rnd48(), i != 2, rnd48(), 1);
        // R1: directed pair low 0xABC then high 0x123
        cyc("R1", 2'd0, 1, 2'd2, 0, rnd48(), 1, 48'h0000_0000_0ABC, 1);
        cyc("R1", 2'd0, 1, 2'd2, 0, 48'h0000_0000_0123, 1, rnd48(), 1);
        for (int i = 0; i < 6; i++) cyc("R1", 2'd0, 1, 2'd2, 0, rnd48(), 1, rnd48(), 1);
        // R3: data-enable drops between halves, then configuration changes
        cyc("R3", 2'd0, 1, 2'd2, 0, rnd48(), 0, rnd48(), 1);
        cyc("R3", 2'd0, 1, 2'd2, 0, rnd48(), 1, rnd48(), 0);
        cyc("R3", 2'd0, 1, 2'd2, 0, rnd48(), 1, rnd48(), 1);
        cyc("R3", 2'd0, 0, 2'd2, 0, rnd48(), 1, rnd48(), 1);
        cyc("R3", 2'd0, 0, 2'd2, 0, rnd48(), 1, rnd48(), 1);
        // R2: opposite order
        for (int i = 0; i < 6; i++) cyc("R2", 2'd0, 1, 2'd2, 1, rnd48(), i != 2, rnd48(), i != 4);
        cyc("R3", 2'd0, 1, 2'd2, 0, rnd48(), 1, rnd48(), 1);
        cyc("R3", 2'd0, 1, 2'd2, 0, rnd48(), 1, rnd48(), 1);
        // R8: every illegal setting
        cyc("R8", 2'd0, 1, 2'd0, 0, rnd48(), 1, rnd48(), 1);
        cyc("R8", 2'd0, 1, 2'd1, 1, rnd48(), 1, rnd48(), 1);
        cyc("R8", 2'd2, 1, 2'd2, 0, rnd48(), 1, rnd48(), 1);
        cyc("R8", 2'd3, 1, 2'd0, 0, rnd48(), 1, rnd48(), 1);
        cyc("R8", 2'd1, 1, 2'd3, 0, rnd48(), 1, rnd48(), 1);
        cyc("R8", 2'd1, 1, 2'd0, 0, rnd48(), 1, rnd48(), 1);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual running expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule